// File: doc/BRIEF.md
# Index/Data Port Watchdog with Unlock Key

This block is a byte-wide configuration window that holds a watchdog timer. Software reaches it through two byte ports, selected by `busSel`: port 0 carries a register index and port 1 carries data for the register that the index names. The index and data ports sit at 0x2E and 0x2F in the host I/O space. The host-bus decode that maps those addresses onto `busSel` lies outside this block.

While the window is closed, the block drops data writes and every read returns 0xFF. To open the window, software writes the key byte 0x87 to the index port twice in a row. It then selects the watchdog page by writing 0x08 through index 0x07. A lock byte written to the index port closes the window again.

The watchdog counts down on one of two tick inputs, which stand in for a seconds prescaler and a minutes prescaler. Software can reload the count, and keyboard or mouse event pulses can also reload it. When the count is zero while the watchdog is enabled, the block raises a reset request.

Top module: `idx_port_watchdog`

## Requirements
- R1: The window opens only after two index-port writes (`busSel`=0) of 0x87 on consecutive writes. While the window is open, an index-port read returns the last index written.
- R2: While exactly one 0x87 has been seen, any index-port write of another value, or any data-port write, returns the block to the closed state.
- R3: While the window is closed, data-port writes change nothing, and reads of either port return 0xFF.
- R4: While the window is open, an index-port write of 0xAA closes it. Later data-port writes are then ignored.
- R5: With the window open, a data write to index 0x07 sets the page number, and index 0x07 reads it back. Indexes 0x30, 0xF5, 0xF6 and 0xF7 are reached only when the page is 0x08. At any other page, writes to those indexes are ignored and reads return 0xFF.
- R6: After reset, the registers read as follows: 0x30 reads 0x00, 0xF5 reads 0x08 (minutes), 0xF6 reads 5 and 0xF7 reads 0x00.
- R7: Bit 0 of register 0x30 enables counting. While it is enabled and the count is non-zero, each selected tick lowers the count by one. While it is disabled, ticks leave the count unchanged.
- R8: Bit 3 of register 0xF5 selects the tick. A value of 0 selects `secTick` and 1 selects `minTick`. The other tick has no effect.
- R9: A write to 0xF6 loads the count and also stores the value as the reload value. A read of 0xF6 returns the current count.
- R10: When bit 6 of 0xF7 is set, a `kbdEvent` pulse copies the reload value into the count. When bit 7 is set, a `mouseEvent` pulse does the same. An event whose bit is clear has no effect.
- R11: `resetReq` is high exactly while the watchdog is enabled and the count is zero. It stays high until a reload or a disable.
- R12: When several updates to the count fall in one cycle, a 0xF6 write takes priority over an event reload, and an event reload takes priority over a tick decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Write strobe, one cycle per byte |
| busRd | input | 1 | Read strobe; `busRData` is valid in the same cycle |
| busSel | input | 1 | Port select: 0 = index port, 1 = data port |
| busWData | input | 8 | Write byte |
| busRData | output | 8 | Read byte; 0xFF when no read is active or access is denied |
| secTick | input | 1 | One-cycle seconds tick |
| minTick | input | 1 | One-cycle minutes tick |
| kbdEvent | input | 1 | One-cycle keyboard event pulse |
| mouseEvent | input | 1 | One-cycle mouse event pulse |
| resetReq | output | 1 | Watchdog reset request |

## Verification
The properties assume that a bus access is a write or a read, never both in one cycle. They also assume that the tick and event inputs are single-cycle pulses sampled on the clock. The stimulus enforces this: every bus operation goes through one task that raises exactly one strobe for one cycle and then clears every input. Where a test needs updates to collide, as in the priority checks, it raises several ticks and events in the same cycle. It never raises a read and a write together.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [7:0] KEY_UNLOCK = 8'h87;
  localparam logic [7:0] KEY_LOCK   = 8'hAA;
  localparam logic [7:0] IDX_PAGE   = 8'h07;
  localparam logic [7:0] PAGE_WDT   = 8'h08;
  localparam logic [7:0] REG_ENABLE = 8'h30;
  localparam logic [7:0] REG_UNIT   = 8'hF5;
  localparam logic [7:0] REG_TIMER  = 8'hF6;
  localparam logic [7:0] REG_EVENT  = 8'hF7;

  localparam int EN_BIT    = 0;
  localparam int UNIT_BIT  = 3;
  localparam int KBD_BIT   = 6;
  localparam int MOUSE_BIT = 7;

  typedef enum logic [1:0] {
    ACC_LOCKED,
    ACC_HALF,
    ACC_OPEN
  } accState_t;

  typedef enum logic [2:0] {
    RD_FF,
    RD_CTRL,
    RD_ENABLE,
    RD_UNIT,
    RD_TIMER,
    RD_EVENT
  } rdSel_t;

  typedef struct packed {
    logic   wrEnable;
    logic   wrUnit;
    logic   wrTimer;
    logic   wrEvent;
    rdSel_t rdSel;
  } dpStrobe_t;
endpackage

// File: rtl/wdt_access_ctrl.sv
module wdt_access_ctrl
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busWr,
  input  logic       busRd,
  input  logic       busSel,
  input  logic [7:0] busWData,
  output dpStrobe_t  strobe,
  output logic [7:0] ctrlRdData
);
  accState_t accState, accNext;
  logic [7:0] idxQ, pageQ;
  logic isOpen, idxWr, dataWr, wdtPage;

  assign isOpen  = (accState == ACC_OPEN);
  assign idxWr   = busWr && !busSel;
  assign dataWr  = busWr && busSel;
  assign wdtPage = (pageQ == PAGE_WDT);

  // unlock / lock sequencer
  always_comb begin
    accNext = accState;
    unique case (accState)
      ACC_LOCKED: if (idxWr && busWData == KEY_UNLOCK) accNext = ACC_HALF;
      ACC_HALF: begin
        if (idxWr) accNext = (busWData == KEY_UNLOCK) ? ACC_OPEN : ACC_LOCKED;
        else if (dataWr) accNext = ACC_LOCKED;
      end
      ACC_OPEN: if (idxWr && busWData == KEY_LOCK) accNext = ACC_LOCKED;
      default: accNext = ACC_LOCKED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accState <= ACC_LOCKED;
      idxQ     <= 8'h00;
      pageQ    <= 8'h00;
    end else begin
      accState <= accNext;
      if (isOpen && idxWr && busWData != KEY_LOCK) idxQ <= busWData;
      if (isOpen && dataWr && idxQ == IDX_PAGE) pageQ <= busWData;
    end
  end

  // decode into datapath strobes
  always_comb begin
    strobe          = '0;
    strobe.rdSel    = RD_FF;
    ctrlRdData      = 8'hFF;
    if (isOpen && dataWr && wdtPage) begin
      strobe.wrEnable = (idxQ == REG_ENABLE);
      strobe.wrUnit   = (idxQ == REG_UNIT);
      strobe.wrTimer  = (idxQ == REG_TIMER);
      strobe.wrEvent  = (idxQ == REG_EVENT);
    end
    if (isOpen && busRd) begin
      if (!busSel) begin
        strobe.rdSel = RD_CTRL;
        ctrlRdData   = idxQ;
      end else if (idxQ == IDX_PAGE) begin
        strobe.rdSel = RD_CTRL;
        ctrlRdData   = pageQ;
      end else if (wdtPage) begin
        unique case (idxQ)
          REG_ENABLE: strobe.rdSel = RD_ENABLE;
          REG_UNIT:   strobe.rdSel = RD_UNIT;
          REG_TIMER:  strobe.rdSel = RD_TIMER;
          REG_EVENT:  strobe.rdSel = RD_EVENT;
          default:    strobe.rdSel = RD_FF;
        endcase
      end
    end
  end

  // R1: the window only opens on a second key byte
  assert_open_needs_key_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(accState == ACC_OPEN) |->
      $past(accState == ACC_HALF && busWr && !busSel && busWData == KEY_UNLOCK));

  // R2: a stray data write during the half-open state restarts the key
  assert_half_restart_R2: assert property (@(posedge clk) disable iff (!rstN)
    (accState == ACC_HALF && busWr && busSel) |=> accState == ACC_LOCKED);

  // R3: nothing reaches the datapath while the window is closed
  assert_closed_no_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    (accState != ACC_OPEN) |->
      !(strobe.wrEnable || strobe.wrUnit || strobe.wrTimer || strobe.wrEvent)
      && strobe.rdSel == RD_FF);

  // R4: lock byte closes the window on the next cycle
  assert_lock_closes_R4: assert property (@(posedge clk) disable iff (!rstN)
    (accState == ACC_OPEN && busWr && !busSel && busWData == KEY_LOCK)
      |=> accState == ACC_LOCKED);
endmodule

// File: rtl/wdt_timer_dp.sv
module wdt_timer_dp
  import wdt_pkg::*;
#(
  parameter logic [7:0] RESET_COUNT   = 8'd5,
  parameter bit         RESET_MINUTES = 1'b1,
  parameter bit         RESET_ENABLE  = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobe_t  strobe,
  input  logic [7:0] wData,
  input  logic [7:0] ctrlRdData,
  input  logic       secTick,
  input  logic       minTick,
  input  logic       kbdEvent,
  input  logic       mouseEvent,
  output logic [7:0] rdData,
  output logic       resetReq
);
  localparam logic [7:0] UNIT_RESET = RESET_MINUTES ? (8'h1 << UNIT_BIT) : 8'h00;
  localparam logic [7:0] EN_RESET   = RESET_ENABLE  ? (8'h1 << EN_BIT)   : 8'h00;

  logic [7:0] enReg, unitReg, eventReg, reloadReg, cntQ;
  logic enOn, tickSel, evReload;

  assign enOn     = enReg[EN_BIT];
  assign tickSel  = unitReg[UNIT_BIT] ? minTick : secTick;
  assign evReload = (kbdEvent && eventReg[KBD_BIT]) || (mouseEvent && eventReg[MOUSE_BIT]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg     <= EN_RESET;
      unitReg   <= UNIT_RESET;
      eventReg  <= 8'h00;
      reloadReg <= RESET_COUNT;
      cntQ      <= RESET_COUNT;
    end else begin
      if (strobe.wrEnable) enReg    <= wData;
      if (strobe.wrUnit)   unitReg  <= wData;
      if (strobe.wrEvent)  eventReg <= wData;
      if (strobe.wrTimer) begin
        reloadReg <= wData;
        cntQ      <= wData;
      end else if (evReload) begin
        cntQ <= reloadReg;
      end else if (enOn && tickSel && cntQ != 8'd0) begin
        cntQ <= cntQ - 8'd1;
      end
    end
  end

  always_comb begin
    unique case (strobe.rdSel)
      RD_CTRL:   rdData = ctrlRdData;
      RD_ENABLE: rdData = enReg;
      RD_UNIT:   rdData = unitReg;
      RD_TIMER:  rdData = cntQ;
      RD_EVENT:  rdData = eventReg;
      default:   rdData = 8'hFF;
    endcase
  end

  assign resetReq = enOn && (cntQ == 8'd0);

  // R7: an enabled tick with nothing else pending lowers the count by one
  assert_tick_decrements_R7: assert property (@(posedge clk) disable iff (!rstN)
    (enOn && tickSel && cntQ != 8'd0 && !strobe.wrTimer && !evReload)
      |=> cntQ == $past(cntQ) - 8'd1);

  // R7: disabled and no reload means the count holds
  assert_disabled_holds_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!enOn && !strobe.wrTimer && !evReload) |=> $stable(cntQ));

  // R11: the request is sticky until reload or disable
  assert_request_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    (resetReq && !strobe.wrTimer && !evReload && !strobe.wrEnable) |=> resetReq);

  // R12: a software load wins over any event reload
  assert_write_wins_R12: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrTimer |=> cntQ == $past(wData));
endmodule

// File: rtl/idx_port_watchdog.sv
module idx_port_watchdog
  import wdt_pkg::*;
#(
  parameter logic [7:0] RESET_COUNT   = 8'd5,
  parameter bit         RESET_MINUTES = 1'b1,
  parameter bit         RESET_ENABLE  = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busWr,
  input  logic       busRd,
  input  logic       busSel,
  input  logic [7:0] busWData,
  output logic [7:0] busRData,
  input  logic       secTick,
  input  logic       minTick,
  input  logic       kbdEvent,
  input  logic       mouseEvent,
  output logic       resetReq
);
  dpStrobe_t  strobe;
  logic [7:0] ctrlRdData;

  wdt_access_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .busWr      (busWr),
    .busRd      (busRd),
    .busSel     (busSel),
    .busWData   (busWData),
    .strobe     (strobe),
    .ctrlRdData (ctrlRdData)
  );

  wdt_timer_dp #(
    .RESET_COUNT   (RESET_COUNT),
    .RESET_MINUTES (RESET_MINUTES),
    .RESET_ENABLE  (RESET_ENABLE)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wData      (busWData),
    .ctrlRdData (ctrlRdData),
    .secTick    (secTick),
    .minTick    (minTick),
    .kbdEvent   (kbdEvent),
    .mouseEvent (mouseEvent),
    .rdData     (busRData),
    .resetReq   (resetReq)
  );
endmodule

// File: tb/tb_idx_port_watchdog.sv
module tb_idx_port_watchdog;
  logic clk = 0;
  logic rstN = 0;
  logic busWr = 0, busRd = 0, busSel = 0;
  logic [7:0] busWData = 0;
  logic [7:0] busRData;
  logic secTick = 0, minTick = 0, kbdEvent = 0, mouseEvent = 0;
  logic resetReq;

  int compared = 0, mismatched = 0;
  int cycles = 0;
  string curReq = "R6";

  // reference model state
  int mState, mIdx, mPage, mEn, mUnit, mEvt, mRel, mCnt;

  always #5 clk = ~clk;

  idx_port_watchdog dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busSel(busSel),
    .busWData(busWData), .busRData(busRData), .secTick(secTick),
    .minTick(minTick), .kbdEvent(kbdEvent), .mouseEvent(mouseEvent),
    .resetReq(resetReq)
  );

  function automatic int modelRead();
    if (mState != 2) return 255;
    if (!busSel) return mIdx;
    if (mIdx == 7) return mPage;
    if (mPage != 8) return 255;
    case (mIdx)
      'h30: return mEn;
      'hF5: return mUnit;
      'hF6: return mCnt;
      'hF7: return mEvt;
      default: return 255;
    endcase
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mState = 0; mIdx = 0; mPage = 0; mEn = 0; mUnit = 8; mEvt = 0; mRel = 5; mCnt = 5;
    end else begin
      automatic bit open = (mState == 2);
      automatic bit wrIdx = busWr && !busSel;
      automatic bit wrDat = busWr && busSel;
      automatic bit tick = (mUnit & 8) ? minTick : secTick;
      automatic bit ev = (kbdEvent && (mEvt & 'h40)) || (mouseEvent && (mEvt & 'h80));
      automatic bit wrT = open && wrDat && mPage == 8 && mIdx == 'hF6;
      if (wrT) begin mCnt = busWData; mRel = busWData; end
      else if (ev) mCnt = mRel;
      else if ((mEn & 1) && tick && mCnt > 0) mCnt--;
      if (open && wrDat) begin
        if (mIdx == 7) mPage = busWData;
        else if (mPage == 8 && mIdx == 'h30) mEn = busWData;
        else if (mPage == 8 && mIdx == 'hF5) mUnit = busWData;
        else if (mPage == 8 && mIdx == 'hF7) mEvt = busWData;
      end
      case (mState)
        0: if (wrIdx && busWData == 'h87) mState = 1;
        1: if (wrIdx) mState = (busWData == 'h87) ? 2 : 0;
           else if (wrDat) mState = 0;
        default: if (wrIdx) begin
          if (busWData == 'hAA) mState = 0; else mIdx = busWData;
        end
      endcase
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      automatic bit expReq = (mEn & 1) && (mCnt == 0);
      compared++;
      if (resetReq !== expReq) begin
        mismatched++;
        $display("FAIL %s resetReq act=%0d exp=%0d t=%0t", curReq, resetReq, expReq, $time);
      end
      if (busRd) begin
        automatic int expRd = modelRead();
        compared++;
        if (busRData !== 8'(expRd)) begin
          mismatched++;
          $display("FAIL %s busRData act=%02h exp=%02h t=%0t", curReq, busRData, expRd, $time);
        end
      end
    end
  end

  task automatic step(input logic wr, input logic rd, input logic sel, input logic [7:0] d,
                      input logic s = 0, input logic m = 0, input logic k = 0, input logic mo = 0);
    busWr = wr; busRd = rd; busSel = sel; busWData = d;
    secTick = s; minTick = m; kbdEvent = k; mouseEvent = mo;
    @(posedge clk); #1;
    busWr = 0; busRd = 0; busSel = 0; busWData = 0;
    secTick = 0; minTick = 0; kbdEvent = 0; mouseEvent = 0;
  endtask

  task automatic idxW(input logic [7:0] d); step(1, 0, 0, d); endtask
  task automatic datW(input logic [7:0] d); step(1, 0, 1, d); endtask
  task automatic rdIdx(); step(0, 1, 0, 0); endtask
  task automatic rdDat(); step(0, 1, 1, 0); endtask
  task automatic wreg(input logic [7:0] a, input logic [7:0] d); idxW(a); datW(d); endtask
  task automatic rreg(input logic [7:0] a); idxW(a); rdDat(); endtask
  task automatic ticks(input logic s, input logic m, input logic k, input logic mo);
    step(0, 0, 0, 0, s, m, k, mo);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R3: closed window ignores writes and reads 0xFF
    curReq = "R3";
    rdIdx(); rdDat(); datW(8'h00); rdDat();
    // R2: broken key sequences restart
    curReq = "R2";
    idxW(8'h87); idxW(8'h12); rdIdx();
    idxW(8'h87); datW(8'h55); rdIdx();
    idxW(8'h87); idxW(8'h86); idxW(8'h87); rdIdx();
    // R1: double key opens the window; index reads back
    curReq = "R1";
    idxW(8'h87); idxW(8'h87); rdIdx(); idxW(8'h30); rdIdx();
    // R5: wrong page hides the watchdog registers
    curReq = "R5";
    rdDat(); datW(8'h01); rreg(8'hF6);
    wreg(8'h07, 8'h03); rreg(8'h07); rreg(8'h30);
    wreg(8'h07, 8'h08); rreg(8'h07);
    // R6: reset values
    curReq = "R6";
    rreg(8'h30); rreg(8'hF5); rreg(8'hF6); rreg(8'hF7);
    // R9: timer load and readback
    curReq = "R9";
    wreg(8'hF6, 8'h03); rreg(8'hF6);
    // R8: seconds unit ignores minTick
    curReq = "R8";
    wreg(8'hF5, 8'h00); rreg(8'hF5);
    // R7: enable and count down
    curReq = "R7";
    wreg(8'h30, 8'h01);
    ticks(0, 1, 0, 0); ticks(1, 0, 0, 0); rreg(8'hF6);
    ticks(1, 0, 0, 0);
    // R11: reaches zero and stays asserted
    curReq = "R11";
    ticks(1, 0, 0, 0); ticks(1, 0, 0, 0); ticks(0, 0, 0, 0); rreg(8'hF6);
    idxW(8'hF6); datW(8'h02); ticks(1, 0, 0, 0); ticks(1, 0, 0, 0);
    wreg(8'h30, 8'h00); ticks(1, 0, 0, 0);
    // R7: disabled holds
    curReq = "R7";
    wreg(8'hF6, 8'h04); ticks(1, 0, 0, 0); rreg(8'hF6);
    // R10: event reload masks
    curReq = "R10";
    wreg(8'h30, 8'h01); ticks(1, 0, 0, 0); ticks(1, 0, 0, 0);
    ticks(0, 0, 1, 1); rreg(8'hF6);
    wreg(8'hF7, 8'h40); ticks(1, 0, 0, 0); ticks(0, 0, 0, 1); rreg(8'hF6);
    ticks(0, 0, 1, 0); rreg(8'hF6);
    wreg(8'hF7, 8'h80); ticks(1, 0, 0, 0); ticks(0, 0, 1, 0); ticks(0, 0, 0, 1); rreg(8'hF6);
    // R12: priority of write over event over tick
    curReq = "R12";
    idxW(8'hF6); step(1, 0, 1, 8'h09, 1, 0, 0, 1); rreg(8'hF6);
    ticks(1, 0, 0, 1); rreg(8'hF6);
    // R8: minutes unit ignores secTick
    curReq = "R8";
    wreg(8'hF5, 8'h08); ticks(1, 0, 0, 0); ticks(0, 1, 0, 0); rreg(8'hF6);
    // R4: lock closes, writes ignored until reopened
    curReq = "R4";
    idxW(8'hAA); rdIdx(); datW(8'h01); rdDat();
    idxW(8'h87); idxW(8'h87); rreg(8'hF6); rreg(8'h30);
    repeat (3) @(posedge clk);
    #1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    wait (cycles > 5000);
    mismatched++;
    $display("FAIL watchdog expired act=%0d exp<=5000 cycles", cycles);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule